// File: doc/BRIEF.md
# Selectable Mantissa Shortening Unit

This combinational unit reduces a long fraction mantissa of W+G bits to its W most significant bits. The G low bits are guard bits that an arithmetic datapath carries through alignment and normalization. A two-bit mode input chooses the policy used to discard them. Chopping simply drops them. The jam policy forces the kept least significant bit to one whenever anything non-zero is dropped. The nearest policy rounds to the closer value and resolves exact halfway cases toward an even result.

Rounding up can carry out of the kept field. When it does, the unit raises a carry flag and presents the wrapped value. Adjusting the exponent and renormalizing are left to the surrounding datapath. The unit has no clock; its outputs follow its inputs through logic alone. W must be at least 2 and G at least 2.

Top module: `mant_shorten`

## Requirements
- R1: With mode 2'b00 (chop), mant_short equals mant_long[W+G-1:G] and carry_out is 0, whatever the guard bits hold.
- R2: With mode 2'b01 (jam), if any of mant_long[G-1:0] is 1, mant_short equals mant_long[W+G-1:G] with bit 0 forced to 1.
- R3: With mode 2'b01 (jam), if mant_long[G-1:0] is all zero, mant_short equals mant_long[W+G-1:G] unchanged.
- R4: With mode 2'b10 (nearest-even), if mant_long[G-1] is 1 and any of mant_long[G-2:0] is 1, mant_short equals the kept field plus one, modulo 2^W.
- R5: With mode 2'b10, if mant_long[G-1] is 0, mant_short equals the kept field unchanged.
- R6: With mode 2'b10, on a tie (mant_long[G-1] is 1 and mant_long[G-2:0] is all zero), a kept field with bit 0 clear is returned unchanged, and a kept field with bit 0 set is incremented.
- R7: When an increment overflows the kept field (kept field all ones), carry_out is 1 and mant_short is all zeros.
- R8: Mode 2'b11 gives exactly the same outputs as mode 2'b00.
- R9: carry_out is 0 in every case except an overflowing increment in mode 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mant_long | input | W+G | Long mantissa; kept field in the upper W bits, guard bits below |
| mode | input | 2 | 00 chop, 01 jam, 10 nearest-even, 11 chop |
| mant_short | output | W | Shortened mantissa (wrapped on overflow) |
| carry_out | output | 1 | Rounding overflowed the kept field; renormalization needed |

## Verification
The bench aims at exact halfway patterns with both parities of the kept bit. A design that always rounds halves up would move even values, and one that always truncates would leave odd values in place. It drives an all-ones kept field under a round-up, where a missing or wrongly sized carry would show up as a non-zero result or a clear flag. It also drives jam mode with an all-ones field, where a design that adds instead of forcing the bit would overflow. Every guard pattern is swept in every mode, including the spare code, to catch a sticky reduction that misses a lower guard bit or a spare mode that falls into a rounding path.

// File: rtl/mant_round_pkg.sv
package mant_round_pkg;

    typedef enum logic [1:0] {
        RM_CHOP      = 2'b00,
        RM_JAM       = 2'b01,
        RM_NEAR_EVEN = 2'b10,
        RM_SPARE     = 2'b11
    } rmode_e;

    // summary of the discarded bits plus the kept LSB
    typedef struct packed {
        logic half;   // most significant discarded bit
        logic below;  // OR of all discarded bits under it
        logic lsb;    // least significant kept bit
    } guard_sum_t;

    typedef struct packed {
        logic bump;       // add one at the kept LSB
        logic force_one;  // set the kept LSB to one
    } round_act_t;

    function automatic round_act_t pick_action(input rmode_e m, input guard_sum_t g);
        round_act_t a;
        a = '0;
        case (m)
            RM_JAM: begin
                a.force_one = g.half | g.below;
            end
            RM_NEAR_EVEN: begin
                a.bump = g.half & (g.below | g.lsb);
            end
            default: a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/guard_split.sv
module guard_split
    import mant_round_pkg::*;
#(
    parameter int W = 24,
    parameter int G = 4
) (
    input  logic [W+G-1:0] mant_long,
    output logic [W-1:0]   kept,
    output guard_sum_t     gsum
);
    localparam int LW = W + G;

    always_comb begin
        kept       = mant_long[LW-1:G];
        gsum.half  = mant_long[G-1];
        gsum.below = |mant_long[G-2:0];
        gsum.lsb   = mant_long[G];
    end
endmodule

// File: rtl/round_decide.sv
module round_decide
    import mant_round_pkg::*;
(
    input  rmode_e     mode,
    input  guard_sum_t gsum,
    output round_act_t act
);
    always_comb begin
        act = pick_action(mode, gsum);
    end
endmodule

// File: rtl/ripple_inc.sv
module ripple_inc #(
    parameter int W = 24
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = a[i] ^ chain[i];
        assign chain[i+1] = a[i] & chain[i];
    end

    assign cout = chain[W];
endmodule

// File: rtl/mant_shorten.sv
module mant_shorten
    import mant_round_pkg::*;
#(
    parameter int W = 24,
    parameter int G = 4
) (
    input  logic [W+G-1:0] mant_long,
    input  logic [1:0]     mode,
    output logic [W-1:0]   mant_short,
    output logic           carry_out
);
    localparam int LW = W + G;

    rmode_e     mode_q;
    logic [W-1:0] kept;
    guard_sum_t gsum;
    round_act_t act;
    logic [W-1:0] inc_sum;
    logic         inc_cout;

    assign mode_q = rmode_e'(mode);

    guard_split #(.W(W), .G(G)) u_split (
        .mant_long (mant_long),
        .kept      (kept),
        .gsum      (gsum)
    );

    round_decide u_decide (
        .mode (mode_q),
        .gsum (gsum),
        .act  (act)
    );

    ripple_inc #(.W(W)) u_inc (
        .a    (kept),
        .cin  (act.bump),
        .sum  (inc_sum),
        .cout (inc_cout)
    );

    always_comb begin
        if (act.force_one) begin
            mant_short = {kept[W-1:1], 1'b1};
        end else begin
            mant_short = inc_sum;
        end
        carry_out = inc_cout;
    end

    always_comb begin
        if (!$isunknown({mant_long, mode})) begin
            // R1
            chop_passthru_chk: assert (!(mode_q == RM_CHOP) ||
                (mant_short == mant_long[LW-1:G] && !carry_out));
            // R8
            spare_as_chop_chk: assert (!(mode_q == RM_SPARE) ||
                (mant_short == mant_long[LW-1:G] && !carry_out));
            // R2
            jam_lsb_chk: assert (!(mode_q == RM_JAM && mant_long[G-1:0] != '0) ||
                (mant_short[0] && mant_short[W-1:1] == mant_long[LW-1:G+1]));
            // R5
            low_guard_keep_chk: assert (!(mode_q == RM_NEAR_EVEN && !mant_long[G-1]) ||
                (mant_short == mant_long[LW-1:G]));
            // R7
            carry_wrap_chk: assert (!carry_out || mant_short == '0);
            // R9
            carry_only_near_chk: assert (!carry_out ||
                (mode_q == RM_NEAR_EVEN && mant_long[LW-1:G] == '1));
        end
    end
endmodule

// File: tb/test_mant_shorten.sv
module test_mant_shorten;
    localparam int W  = 4;
    localparam int G  = 3;
    localparam int LW = W + G;
    localparam int NV = 12;

    logic clk;
    logic rst;
    logic [LW-1:0] mant_long;
    logic [1:0]    mode;
    logic [W-1:0]  mant_short;
    logic          carry_out;

    int n_checks;
    int n_fail;
    bit done;

    mant_shorten #(.W(W), .G(G)) i_mant_shorten (
        .mant_long  (mant_long),
        .mode       (mode),
        .mant_short (mant_short),
        .carry_out  (carry_out)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // {mode, long(kept4, guard3), expected short, expected carry}
    localparam logic [13:0] VEC [NV] = '{
        {2'b00, 7'b1011_111, 4'b1011, 1'b0},
        {2'b11, 7'b1011_111, 4'b1011, 1'b0},
        {2'b01, 7'b1010_001, 4'b1011, 1'b0},
        {2'b01, 7'b1010_000, 4'b1010, 1'b0},
        {2'b01, 7'b1111_100, 4'b1111, 1'b0},
        {2'b10, 7'b0101_101, 4'b0110, 1'b0},
        {2'b10, 7'b0101_011, 4'b0101, 1'b0},
        {2'b10, 7'b0100_100, 4'b0100, 1'b0},
        {2'b10, 7'b0101_100, 4'b0110, 1'b0},
        {2'b10, 7'b1111_110, 4'b0000, 1'b1},
        {2'b10, 7'b1111_100, 4'b0000, 1'b1},
        {2'b00, 7'b0000_000, 4'b0000, 1'b0}
    };
    string vtag [NV];

    // independent reference: integer arithmetic on the guard value
    function automatic logic [W:0] ref_round(input int m, input int lv);
        int kept, rem, half, res;
        kept = lv >> G;
        rem  = lv % (1 << G);
        half = 1 << (G - 1);
        res  = kept;
        if (m == 1) begin
            if (rem != 0) res = kept | 1;
        end else if (m == 2) begin
            if (rem > half) res = kept + 1;
            else if (rem == half && (kept % 2) == 1) res = kept + 1;
        end
        return res[W:0];
    endfunction

    task automatic check(input string tag, input logic [W-1:0] exp_s, input logic exp_c);
        n_checks++;
        if (mant_short !== exp_s || carry_out !== exp_c) begin
            n_fail++;
            $display("FAIL %s mode=%b long=%b: got short=%b carry=%b, expected short=%b carry=%b",
                     tag, mode, mant_long, mant_short, carry_out, exp_s, exp_c);
        end
    endtask

    initial begin
        vtag = '{"R1", "R8", "R2", "R3", "R2 R9", "R4", "R5",
                 "R6 even", "R6 odd", "R7", "R7 tie", "R1 zero"};
        n_checks = 0;
        n_fail   = 0;
        done     = 1'b0;
        rst      = 1'b1;
        mant_long = '0;
        mode      = 2'b00;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 initial zero", 4'b0000, 1'b0);

        for (int v = 0; v < NV; v++) begin
            @(posedge clk);
            mode      = VEC[v][13:12];
            mant_long = VEC[v][11:5];
            @(negedge clk);
            check(vtag[v], VEC[v][4:1], VEC[v][0]);
        end

        // exhaustive sweep of every mode and input value
        for (int m = 0; m < 4; m++) begin
            for (int lv = 0; lv < (1 << LW); lv++) begin
                logic [W:0] r;
                @(posedge clk);
                mode      = m[1:0];
                mant_long = lv[LW-1:0];
                r = ref_round((m == 3) ? 0 : m, lv);
                @(negedge clk);
                case (m)
                    0: check("R1 sweep", r[W-1:0], r[W]);
                    1: check("R2 R3 sweep", r[W-1:0], r[W]);
                    2: check("R4 R5 R6 R7 sweep", r[W-1:0], r[W]);
                    default: check("R8 sweep", r[W-1:0], r[W]);
                endcase
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired: got running, expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule